// File: doc/BRIEF.md
# Seven-to-One Pixel Link Deserializer

This block sits behind the line receivers of a narrow serial video link. Three data lanes and one forwarded clock lane arrive as single-ended bits, all sampled on a bit clock that runs seven times the pixel rate. The block watches the clock lane for its frame marker: four high bits followed by three low bits. The first high bit after the three lows marks the start of a pixel frame. Once the block has aligned to that marker, it gathers the seven bits of each lane into one 21-bit parallel word. The word holds 18 colour bits plus line sync, frame sync and data ready. The block also rebuilds a pixel clock from the bit clock.

The parallel word is meant to be captured by a downstream register on the falling edge of the recovered pixel clock. For that reason the word is only updated on the same bit-clock edge that raises the pixel clock. The block reports alignment on a locked flag. It only declares lock after two back-to-back frames show the marker at the same bit offset. It drops lock as soon as an expected frame boundary lacks the marker. An active-low power-down input silences every output at once and discards the alignment.

Top module: `pixel_deser`

## Requirements
- R1: Bit j (0 = first received) of lane L lands in pix_word[7*L + j], so lane 0 fills bits 0..6, lane 1 bits 7..13 and lane 2 bits 14..20.
- R2: The word layout is pix_word[17:0] colour, pix_word[18] line sync, pix_word[19] frame sync, pix_word[20] data ready; each of these bits is carried through unchanged.
- R3: pix_word changes only on the bit-clock edge where pix_clk rises, and it holds its value for the rest of the frame.
- R4: While locked, pix_clk is high for 4 bit clocks and low for 3. It rises on the edge that samples the last bit of a frame, which is the same edge that presents that frame's word.
- R5: A frame counts as aligned when its seven clock-lane bits, in arrival order, are 1,1,1,1,0,0,0. locked rises, and the word appears, at the end of the second consecutive aligned frame at one offset, never after the first.
- R6: If an expected boundary does not carry the marker, locked and pix_clk go low on that edge and pix_word keeps its last value.
- R7: After lock loss, including a shift of the bit offset, the block relocks at the new offset after two aligned frames.
- R8: While pwr_dn_n is low, pix_word, pix_clk and locked read 0 with no clock delay. Power-down clears the held word and the alignment, so after release pix_word stays 0 until two fresh aligned frames arrive.
- R9: After reset, all outputs are 0 and the block is unlocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Serial bit clock, seven per pixel |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_dn_n | input | 1 | Active-low power-down |
| data_lane | input | 3 | Serial data lanes, one bit per bit clock |
| clk_lane | input | 1 | Forwarded clock lane carrying the frame marker |
| pix_word | output | 21 | Rebuilt parallel pixel word |
| pix_clk | output | 1 | Recovered pixel clock |
| locked | output | 1 | Frame alignment established |

## Verification
Power-down and word capture can both fall on the same bit-clock edge. When they do, power-down must win and the captured frame must never reach the outputs. The bench provokes this by dropping pwr_dn_n in the half cycle just before the final bit of a frame while the block is locked. It then checks three things: the outputs go to zero straight away, they stay at zero across the capture edge, and after release the word still reads zero rather than that frame, until two fresh aligned frames have arrived. A second collision pits the lock-loss decision against word capture at a shifted boundary; there the previous word must be kept.

// File: rtl/pixel_deser_pkg.sv
package pixel_deser_pkg;
    typedef enum logic [1:0] {
        ST_HUNT    = 2'd0,
        ST_CONFIRM = 2'd1,
        ST_TRACK   = 2'd2
    } align_st_e;
endpackage

// File: rtl/lane_shift.sv
module lane_shift #(
    parameter int unsigned BITS = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            din,
    output logic [BITS-1:0] bits_next
);
    logic [BITS-1:0] sr_d, sr_q;

    // newest bit enters at the top; bit 0 is the oldest of the window
    always_comb begin
        sr_d = {din, sr_q[BITS-1:1]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= sr_d;
    end

    assign bits_next = sr_d;
endmodule

// File: rtl/frame_align.sv
module frame_align
    import pixel_deser_pkg::*;
#(
    parameter int unsigned     BITS      = 7,
    parameter int unsigned     PCLK_HIGH = 4,
    parameter logic [BITS-1:0] MARKER    = 7'b0001111
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            enable,
    input  logic [BITS-1:0] marker_win,
    output logic            capture,
    output logic            locked_o,
    output logic            pclk_o
);
    localparam int unsigned PW = (BITS > 1) ? $clog2(BITS) : 1;
    localparam logic [PW-1:0] LAST_PH = PW'(BITS - 1);
    localparam logic [PW-1:0] HIGH_PH = PW'(PCLK_HIGH);

    typedef struct packed {
        align_st_e     st;
        logic [PW-1:0] phase;
        logic          locked;
        logic          pclk;
    } align_t;

    align_t r_q, r_d;
    logic   hit;
    logic   at_edge;

    always_comb begin
        r_d     = r_q;
        capture = 1'b0;
        hit     = (marker_win == MARKER);
        at_edge = (r_q.phase == LAST_PH);
        r_d.phase = at_edge ? '0 : r_q.phase + 1'b1;
        unique case (r_q.st)
            ST_HUNT: begin
                if (hit) begin
                    r_d.st    = ST_CONFIRM;
                    r_d.phase = '0;
                end
            end
            ST_CONFIRM: begin
                if (at_edge) begin
                    if (hit) begin
                        r_d.st  = ST_TRACK;
                        capture = 1'b1;
                    end else begin
                        r_d.st = ST_HUNT;
                    end
                end
            end
            ST_TRACK: begin
                if (at_edge) begin
                    if (hit) capture = 1'b1;
                    else     r_d.st  = ST_HUNT;
                end
            end
            default: r_d.st = ST_HUNT;
        endcase
        if (!enable) begin
            r_d.st  = ST_HUNT;
            capture = 1'b0;
        end
        r_d.locked = (r_d.st == ST_TRACK);
        r_d.pclk   = r_d.locked && (r_d.phase < HIGH_PH);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: ST_HUNT, phase: '0, locked: 1'b0, pclk: 1'b0};
        else        r_q <= r_d;
    end

    assign locked_o = r_q.locked;
    assign pclk_o   = r_q.pclk;
endmodule

// File: rtl/pixel_deser.sv
module pixel_deser #(
    parameter int unsigned     LANES     = 3,
    parameter int unsigned     BITS      = 7,
    parameter int unsigned     PCLK_HIGH = 4,
    parameter logic [BITS-1:0] MARKER    = 7'b0001111
) (
    input  logic                    bit_clk,
    input  logic                    rst_n,
    input  logic                    pwr_dn_n,
    input  logic [LANES-1:0]        data_lane,
    input  logic                    clk_lane,
    output logic [LANES*BITS-1:0]   pix_word,
    output logic                    pix_clk,
    output logic                    locked
);
    localparam int unsigned WORD_W = LANES * BITS;

    logic [WORD_W-1:0] gathered;
    logic [BITS-1:0]   marker_win;
    logic              capture;
    logic              lock_int;
    logic              pclk_int;
    logic [WORD_W-1:0] word_d, word_q;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        lane_shift #(.BITS(BITS)) u_shift (
            .clk      (bit_clk),
            .rst_n    (rst_n),
            .din      (data_lane[l]),
            .bits_next(gathered[l*BITS +: BITS])
        );
    end

    lane_shift #(.BITS(BITS)) u_marker (
        .clk      (bit_clk),
        .rst_n    (rst_n),
        .din      (clk_lane),
        .bits_next(marker_win)
    );

    frame_align #(.BITS(BITS), .PCLK_HIGH(PCLK_HIGH), .MARKER(MARKER)) u_align (
        .clk       (bit_clk),
        .rst_n     (rst_n),
        .enable    (pwr_dn_n),
        .marker_win(marker_win),
        .capture   (capture),
        .locked_o  (lock_int),
        .pclk_o    (pclk_int)
    );

    always_comb begin
        word_d = word_q;
        if (capture)   word_d = gathered;
        if (!pwr_dn_n) word_d = '0;
    end

    always_ff @(posedge bit_clk or negedge rst_n) begin
        if (!rst_n) word_q <= '0;
        else        word_q <= word_d;
    end

    // power-down silences the pins without waiting for a clock
    assign pix_word = pwr_dn_n ? word_q   : '0;
    assign pix_clk  = pwr_dn_n & pclk_int;
    assign locked   = pwr_dn_n & lock_int;
endmodule

// File: rtl/pixel_deser_chk.sv
module pixel_deser_chk #(
    parameter int unsigned     LANES  = 3,
    parameter int unsigned     BITS   = 7,
    parameter logic [BITS-1:0] MARKER = 7'b0001111
) (
    input logic                  bit_clk,
    input logic                  rst_n,
    input logic                  pwr_dn_n,
    input logic                  clk_lane,
    input logic [LANES*BITS-1:0] pix_word,
    input logic                  pix_clk,
    input logic                  locked
);
    logic [BITS-1:0] hist_q;

    always_ff @(posedge bit_clk or negedge rst_n) begin
        if (!rst_n) hist_q <= '0;
        else        hist_q <= {clk_lane, hist_q[BITS-1:1]};
    end

    // R8: power-down silences every output
    p_pd_quiet_r8: assert property (@(posedge bit_clk) disable iff (!rst_n)
        !pwr_dn_n |-> (pix_word == '0 && !pix_clk && !locked));

    // R3: word moves only together with a pixel-clock rise
    p_word_edge_r3: assert property (@(posedge bit_clk) disable iff (!rst_n)
        (pwr_dn_n && $past(pwr_dn_n) && !$stable(pix_word)) |-> $rose(pix_clk));

    // R4: four bit clocks high, then low
    p_pclk_shape_r4: assert property (@(posedge bit_clk) disable iff (!rst_n || !pwr_dn_n)
        $rose(pix_clk) |=> pix_clk ##1 pix_clk ##1 pix_clk ##1 !pix_clk);

    // R5: lock rises only right after a full marker window
    p_lock_marker_r5: assert property (@(posedge bit_clk) disable iff (!rst_n)
        $rose(locked) |-> (hist_q == MARKER));

    // R6: no pixel clock without lock
    p_pclk_locked_r6: assert property (@(posedge bit_clk) disable iff (!rst_n)
        pix_clk |-> locked);
endmodule

bind pixel_deser pixel_deser_chk #(.LANES(LANES), .BITS(BITS), .MARKER(MARKER)) u_chk (
    .bit_clk (bit_clk),
    .rst_n   (rst_n),
    .pwr_dn_n(pwr_dn_n),
    .clk_lane(clk_lane),
    .pix_word(pix_word),
    .pix_clk (pix_clk),
    .locked  (locked)
);

// File: tb/pixel_deser_tb.sv
module pixel_deser_tb;
    localparam logic [6:0] GOOD = 7'b0001111;   // bit b is sent in slot b

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pwr_dn_n = 1'b1;
    logic [2:0]  lane = '0;
    logic        ck_lane = 1'b0;
    logic [20:0] pix_word;
    logic        pix_clk;
    logic        locked;
    int          checks = 0;
    int          fails = 0;

    always #5 clk = ~clk;

    pixel_deser u_dut (
        .bit_clk  (clk),
        .rst_n    (rst_n),
        .pwr_dn_n (pwr_dn_n),
        .data_lane(lane),
        .clk_lane (ck_lane),
        .pix_word (pix_word),
        .pix_clk  (pix_clk),
        .locked   (locked)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%0h exp=%0h", req, got, exp);
        end
    endtask

    task automatic drive_bit(input logic [20:0] w, input logic [6:0] cp, input int b);
        for (int l = 0; l < 3; l++) lane[l] = w[l*7 + b];
        ck_lane = cp[b];
    endtask

    task automatic send_frame(input logic [20:0] w, input logic [6:0] cp);
        for (int b = 0; b < 7; b++) begin
            @(negedge clk);
            drive_bit(w, cp, b);
            @(posedge clk);
        end
        #1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            lane = '0;
            ck_lane = 1'b0;
            @(posedge clk);
        end
        #1;
    endtask

    task automatic t_reset;
        chk("R9 word", 32'(pix_word), 0);
        chk("R9 pclk", 32'(pix_clk), 0);
        chk("R9 locked", 32'(locked), 0);
    endtask

    task automatic t_first_lock;
        idle(3);
        send_frame(21'h0A5F3C, GOOD);
        chk("R5 not after one frame", 32'(locked), 0);
        chk("R5 no word yet", 32'(pix_word), 0);
        send_frame(21'h13579B, GOOD);
        chk("R5 locked after two", 32'(locked), 1);
        chk("R1 word", 32'(pix_word), 32'h13579B);
        chk("R4 pclk rises at boundary", 32'(pix_clk), 1);
    endtask

    task automatic t_pclk_shape;
        logic [20:0] w;
        w = 21'h1C0E07;
        for (int b = 0; b < 7; b++) begin
            @(negedge clk);
            drive_bit(w, GOOD, b);
            @(posedge clk);
            #1;
            if (b < 6) begin
                chk("R4 pclk mid frame", 32'(pix_clk), (b < 3) ? 1 : 0);
                chk("R3 word held", 32'(pix_word), 32'h13579B);
            end else begin
                chk("R3 word at rise", 32'(pix_word), 32'(w));
                chk("R4 pclk high at boundary", 32'(pix_clk), 1);
            end
        end
    endtask

    task automatic t_mapping;
        logic [20:0] pats [6];
        pats[0] = 21'h000001; pats[1] = 21'h000040; pats[2] = 21'h000080;
        pats[3] = 21'h100000; pats[4] = 21'h12D5A3; pats[5] = 21'h1FFFFF;
        for (int i = 0; i < 6; i++) begin
            send_frame(pats[i], GOOD);
            chk("R1 lane mapping", 32'(pix_word), 32'(pats[i]));
        end
        send_frame(21'h040000, GOOD);
        chk("R2 line sync bit 18", 32'(pix_word[18]), 1);
        send_frame(21'h080000, GOOD);
        chk("R2 frame sync bit 19", 32'(pix_word[19]), 1);
        send_frame(21'h13FFFF, GOOD);
        chk("R2 colour and ready", 32'(pix_word), 32'h13FFFF);
    endtask

    task automatic t_loss;
        send_frame(21'h055555, GOOD);
        send_frame(21'h1AAAAA, 7'b0000000);
        chk("R6 locked drops", 32'(locked), 0);
        chk("R6 pclk low", 32'(pix_clk), 0);
        chk("R6 word held", 32'(pix_word), 32'h055555);
        send_frame(21'h0F0F0F, GOOD);
        chk("R7 one frame not enough", 32'(locked), 0);
        send_frame(21'h10F0F0, GOOD);
        chk("R7 relocked", 32'(locked), 1);
        chk("R7 word", 32'(pix_word), 32'h10F0F0);
    endtask

    task automatic t_offset;
        idle(2);
        send_frame(21'h0ABCDE, GOOD);
        chk("R7 shifted offset unlocks", 32'(locked), 0);
        chk("R6 word kept on shift", 32'(pix_word), 32'h10F0F0);
        send_frame(21'h1EDCBA, GOOD);
        chk("R7 locked at new offset", 32'(locked), 1);
        chk("R7 word new offset", 32'(pix_word), 32'h1EDCBA);
    endtask

    task automatic t_powerdown;
        logic [20:0] w;
        w = 21'h0C3C3C;
        for (int b = 0; b < 6; b++) begin
            @(negedge clk);
            drive_bit(w, GOOD, b);
            @(posedge clk);
        end
        @(negedge clk);
        drive_bit(w, GOOD, 6);
        pwr_dn_n = 1'b0;
        #1;
        chk("R8 immediate word", 32'(pix_word), 0);
        chk("R8 immediate lock", 32'(locked), 0);
        chk("R8 immediate pclk", 32'(pix_clk), 0);
        @(posedge clk);
        #1;
        chk("R8 capture edge suppressed", 32'(pix_word), 0);
        send_frame(21'h111111, GOOD);
        chk("R8 stays quiet", 32'({pix_word, pix_clk, locked}), 0);
        @(negedge clk);
        pwr_dn_n = 1'b1;
        #1;
        chk("R8 word cleared", 32'(pix_word), 0);
        chk("R8 lock cleared", 32'(locked), 0);
        send_frame(21'h0FEDCB, GOOD);
        chk("R8 needs two frames", 32'(locked), 0);
        send_frame(21'h1DEAD5, GOOD);
        chk("R8 relock", 32'(locked), 1);
        chk("R8 word after relock", 32'(pix_word), 32'h1DEAD5);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        t_reset;
        rst_n = 1'b1;
        t_first_lock;
        t_pclk_shape;
        t_mapping;
        t_loss;
        t_offset;
        t_powerdown;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired got=0 exp=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule